// File: doc/BRIEF.md
# ATA PIO access timing engine

This block runs one host-side ATA programmed-I/O access from start to finish. A one-cycle start pulse launches the access. The engine then steps through four timed phases, each with its own count:
- address setup before the strobe;
- the active read or write strobe;
- a write-data hold that runs after the strobe drops;
- an end-of-cycle recovery.

A count value n keeps its phase for n+1 clock cycles. The write-data hold overlaps the recovery, so a whole access lasts (T1+1)+(T2+1)+(Teoc+1) cycles plus any strobe stretch.

Three timing sets are presented on the ports: one shared compatible set and one fast set for each of the two devices. The engine latches one of them when the access starts. The fast set of a device is used only for a data-port access to that device while its fast enable is set. Each set carries its own enable for stretching the strobe while the device holds IORDY low. A read latches the device data at the end of the strobe. A write drives the data-bus output enable. A single-cycle done pulse closes every access.

After either reset the engine is idle with both strobes and the output enable low. Its internal copy of the timing set then holds the mode-0 counts given by parameters.

Top module: `pio_access_engine`

## Requirements
- R1: After `go` is sampled high in idle, the active strobe first rises after T1+1 cycles of setup. It stays high for T2+1 cycles when not stretched. `done` is high in the cycle that follows T1+T2+Teoc+3 cycles after the first setup cycle.
- R2: `done` is a pulse of exactly one cycle, issued once per access.
- R3: When `wr`=1, only `wr_strobe` pulses. `dd_oe` is high from the first setup cycle through the strobe. It then stays high for min(T4,Teoc)+1 cycles after the strobe falls.
- R4: When `wr`=0, only `rd_strobe` pulses and `dd_oe` stays low. `rd_data` takes the `dd_in` value present in the last strobe cycle.
- R5: The access uses fast set 0 or fast set 1 (chosen by `dev_sel`=0 or 1) only when `addr`=4'b0000 (the data port) and the `fast_en` bit of that device is 1. Every other access uses the compatible set.
- R6: When the iordy enable of the latched set is 1, the strobe does not end while `iordy` is low, so each low cycle after the counted width adds one cycle. When that enable is 0, `iordy` has no effect on the strobe.
- R7: A `go` pulse that arrives while an access is running has no effect on that access's timing, its `done` count, or the bus afterwards.
- R8: Asserting `rst_n`=0 (asynchronous) or `sync_rst`=1 (at a clock edge) returns the engine to idle with both strobes, `dd_oe` and `done` low. No `done` appears for the aborted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start pulse for one access |
| wr | input | 1 | Direction: 1 write, 0 read |
| addr | input | AW | Register address; 0000 is the data port |
| dev_sel | input | 1 | Selected device (0 or 1) |
| fast_en0 | input | 1 | Fast data-port timing enable, device 0 |
| fast_en1 | input | 1 | Fast data-port timing enable, device 1 |
| cmp_t1 | input | 8 | Compatible set: setup count |
| cmp_t2 | input | 8 | Compatible set: strobe count |
| cmp_t4 | input | 8 | Compatible set: write hold count |
| cmp_teoc | input | 8 | Compatible set: recovery count |
| cmp_iordy_en | input | 1 | Compatible set: IORDY stretch enable |
| f0_t1 | input | 8 | Device 0 fast set: setup count |
| f0_t2 | input | 8 | Device 0 fast set: strobe count |
| f0_t4 | input | 8 | Device 0 fast set: write hold count |
| f0_teoc | input | 8 | Device 0 fast set: recovery count |
| f0_iordy_en | input | 1 | Device 0 fast set: IORDY stretch enable |
| f1_t1 | input | 8 | Device 1 fast set: setup count |
| f1_t2 | input | 8 | Device 1 fast set: strobe count |
| f1_t4 | input | 8 | Device 1 fast set: write hold count |
| f1_teoc | input | 8 | Device 1 fast set: recovery count |
| f1_iordy_en | input | 1 | Device 1 fast set: IORDY stretch enable |
| iordy | input | 1 | Synchronized device ready |
| dd_in | input | DW | Data from the device bus |
| dd_oe | output | 1 | Data-bus output enable |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| rd_data | output | DW | Captured read data |
| done | output | 1 | Access complete pulse |

## Verification
The hardest case to reach is a strobe stretch under a fast set. It needs the data-port address, a matching device select and that device's fast enable all at once, while `iordy` is released exactly at a chosen cycle. The bench gives the three sets distinct setup and strobe counts and different stretch enables. It holds `iordy` low until a release cycle it computes from the set it expects. The chosen set can then be read off where the strobe starts and how long it lasts. Read capture timing is exposed by changing `dd_in` every cycle, so the captured word names the cycle in which it was sampled.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic             iordy_en;
    logic [CNT_W-1:0] t1;
    logic [CNT_W-1:0] t2;
    logic [CNT_W-1:0] t4;
    logic [CNT_W-1:0] teoc;
  } timing_set_t;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;
endpackage

// File: rtl/pio_down_counter.sv
module pio_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sync_rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pio_timing_select.sv
module pio_timing_select
  import pio_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DATA_ADDR = 0
) (
  input  logic [AW-1:0]     addr,
  input  logic              dev_sel,
  input  logic [1:0]        fast_en,
  input  timing_set_t       compat_set,
  input  timing_set_t [1:0] fast_set,
  output timing_set_t       sel_set
);
  logic is_data_port;
  logic use_fast;

  always_comb begin
    is_data_port = (addr == AW'(DATA_ADDR));
    use_fast     = is_data_port && fast_en[dev_sel];
    sel_set      = use_fast ? fast_set[dev_sel] : compat_set;
  end
endmodule

// File: rtl/pio_sequencer.sv
module pio_sequencer
  import pio_pkg::*;
#(
  parameter int DW     = 16,
  parameter int M0_T1  = 6,
  parameter int M0_T2  = 28,
  parameter int M0_T4  = 2,
  parameter int M0_EOC = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_rst,
  input  logic             go,
  input  logic             wr,
  input  timing_set_t      sel_set,
  input  logic             iordy,
  input  logic [DW-1:0]    dd_in,
  input  logic             phase_zero,
  input  logic             hold_zero,
  output logic             phase_load,
  output logic [CNT_W-1:0] phase_val,
  output logic             phase_dec,
  output logic             hold_load,
  output logic [CNT_W-1:0] hold_val,
  output logic             hold_dec,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic             dd_oe,
  output logic             done,
  output logic [DW-1:0]    rd_data
);
  localparam timing_set_t RST_SET = '{
    iordy_en: 1'b0,
    t1:       CNT_W'(M0_T1),
    t2:       CNT_W'(M0_T2),
    t4:       CNT_W'(M0_T4),
    teoc:     CNT_W'(M0_EOC)
  };

  phase_e      state_q, state_d;
  timing_set_t set_q, set_d;
  logic        wr_q, wr_d;
  logic        hold_q, hold_d;
  logic        done_q, done_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic        stall;

  always_comb begin
    state_d    = state_q;
    set_d      = set_q;
    wr_d       = wr_q;
    hold_d     = hold_q;
    done_d     = 1'b0;
    rdat_d     = rdat_q;
    phase_load = 1'b0;
    phase_val  = '0;
    phase_dec  = 1'b0;
    hold_load  = 1'b0;
    stall      = set_q.iordy_en && !iordy;
    case (state_q)
      PH_IDLE: begin
        if (go) begin
          state_d    = PH_SETUP;
          set_d      = sel_set;
          wr_d       = wr;
          phase_load = 1'b1;
          phase_val  = sel_set.t1;
        end
      end
      PH_SETUP: begin
        if (phase_zero) begin
          state_d    = PH_STROBE;
          phase_load = 1'b1;
          phase_val  = set_q.t2;
        end else begin
          phase_dec = 1'b1;
        end
      end
      PH_STROBE: begin
        if (phase_zero && !stall) begin
          state_d    = PH_RECOVER;
          phase_load = 1'b1;
          phase_val  = set_q.teoc;
          hold_load  = 1'b1;
          hold_d     = wr_q;
          if (!wr_q) begin
            rdat_d = dd_in;
          end
        end else begin
          phase_dec = 1'b1;
        end
      end
      PH_RECOVER: begin
        if (phase_zero) begin
          state_d = PH_IDLE;
          done_d  = 1'b1;
          hold_d  = 1'b0;
        end else begin
          phase_dec = 1'b1;
          if (hold_zero) begin
            hold_d = 1'b0;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      set_q   <= RST_SET;
      wr_q    <= 1'b0;
      hold_q  <= 1'b0;
      done_q  <= 1'b0;
      rdat_q  <= '0;
    end else if (sync_rst) begin
      state_q <= PH_IDLE;
      set_q   <= RST_SET;
      wr_q    <= 1'b0;
      hold_q  <= 1'b0;
      done_q  <= 1'b0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      set_q   <= set_d;
      wr_q    <= wr_d;
      hold_q  <= hold_d;
      done_q  <= done_d;
      rdat_q  <= rdat_d;
    end
  end

  assign hold_val  = set_q.t4;
  assign hold_dec  = (state_q == PH_RECOVER);
  assign rd_strobe = (state_q == PH_STROBE) && !wr_q;
  assign wr_strobe = (state_q == PH_STROBE) && wr_q;
  assign dd_oe     = wr_q && ((state_q == PH_SETUP) || (state_q == PH_STROBE) ||
                              ((state_q == PH_RECOVER) && hold_q));
  assign done      = done_q;
  assign rd_data   = rdat_q;

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    !(rd_strobe && wr_strobe));
  assert_read_no_oe_R4: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    rd_strobe |-> !dd_oe);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    done |=> !done);
  assert_setup_first_R1: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    (state_q == PH_IDLE && go) |=> (!rd_strobe && !wr_strobe && state_q == PH_SETUP));
  assert_iordy_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    (state_q == PH_STROBE && phase_zero && set_q.iordy_en && !iordy) |=> (rd_strobe || wr_strobe));
  assert_busy_go_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    (state_q != PH_IDLE) |=> $stable(set_q));
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    done |-> (!rd_strobe && !wr_strobe && !dd_oe));
endmodule

// File: rtl/pio_access_engine.sv
module pio_access_engine
  import pio_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int DATA_ADDR = 0,
  parameter int M0_T1     = 6,
  parameter int M0_T2     = 28,
  parameter int M0_T4     = 2,
  parameter int M0_EOC    = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_rst,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic          dev_sel,
  input  logic          fast_en0,
  input  logic          fast_en1,
  input  logic [7:0]    cmp_t1,
  input  logic [7:0]    cmp_t2,
  input  logic [7:0]    cmp_t4,
  input  logic [7:0]    cmp_teoc,
  input  logic          cmp_iordy_en,
  input  logic [7:0]    f0_t1,
  input  logic [7:0]    f0_t2,
  input  logic [7:0]    f0_t4,
  input  logic [7:0]    f0_teoc,
  input  logic          f0_iordy_en,
  input  logic [7:0]    f1_t1,
  input  logic [7:0]    f1_t2,
  input  logic [7:0]    f1_t4,
  input  logic [7:0]    f1_teoc,
  input  logic          f1_iordy_en,
  input  logic          iordy,
  input  logic [DW-1:0] dd_in,
  output logic          dd_oe,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  timing_set_t       compat_set;
  timing_set_t [1:0] fast_set;
  timing_set_t       sel_set;

  logic             phase_load, phase_dec, phase_zero;
  logic             hold_load, hold_dec, hold_zero;
  logic [CNT_W-1:0] phase_val, hold_val;

  assign compat_set  = '{iordy_en: cmp_iordy_en, t1: cmp_t1, t2: cmp_t2, t4: cmp_t4, teoc: cmp_teoc};
  assign fast_set[0] = '{iordy_en: f0_iordy_en, t1: f0_t1, t2: f0_t2, t4: f0_t4, teoc: f0_teoc};
  assign fast_set[1] = '{iordy_en: f1_iordy_en, t1: f1_t1, t2: f1_t2, t4: f1_t4, teoc: f1_teoc};

  pio_timing_select #(.AW(AW), .DATA_ADDR(DATA_ADDR)) u_select (
    .addr       (addr),
    .dev_sel    (dev_sel),
    .fast_en    ({fast_en1, fast_en0}),
    .compat_set (compat_set),
    .fast_set   (fast_set),
    .sel_set    (sel_set)
  );

  pio_sequencer #(
    .DW(DW), .M0_T1(M0_T1), .M0_T2(M0_T2), .M0_T4(M0_T4), .M0_EOC(M0_EOC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_rst   (sync_rst),
    .go         (go),
    .wr         (wr),
    .sel_set    (sel_set),
    .iordy      (iordy),
    .dd_in      (dd_in),
    .phase_zero (phase_zero),
    .hold_zero  (hold_zero),
    .phase_load (phase_load),
    .phase_val  (phase_val),
    .phase_dec  (phase_dec),
    .hold_load  (hold_load),
    .hold_val   (hold_val),
    .hold_dec   (hold_dec),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .dd_oe      (dd_oe),
    .done       (done),
    .rd_data    (rd_data)
  );

  pio_down_counter #(.W(CNT_W)) u_phase_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_rst (sync_rst),
    .load     (phase_load),
    .load_val (phase_val),
    .dec      (phase_dec),
    .zero     (phase_zero)
  );

  pio_down_counter #(.W(CNT_W)) u_hold_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_rst (sync_rst),
    .load     (hold_load),
    .load_val (hold_val),
    .dec      (hold_dec),
    .zero     (hold_zero)
  );

  assert_write_oe_R3: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    wr_strobe |-> dd_oe);
  assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n || sync_rst)
    $fell(dd_oe) |-> !wr_strobe);
endmodule

// File: tb/pio_access_engine_tb.sv
module pio_access_engine_tb;
  logic clk = 1'b0;
  logic rst_n, sync_rst, go, wr, dev_sel, fast_en0, fast_en1, iordy;
  logic [3:0] addr;
  logic [7:0] cmp_t1, cmp_t2, cmp_t4, cmp_teoc, f0_t1, f0_t2, f0_t4, f0_teoc;
  logic [7:0] f1_t1, f1_t2, f1_t4, f1_teoc;
  logic cmp_iordy_en, f0_iordy_en, f1_iordy_en;
  logic [15:0] dd_in, rd_data;
  logic dd_oe, rd_strobe, wr_strobe, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pio_access_engine u_dut (
    .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .go(go), .wr(wr), .addr(addr),
    .dev_sel(dev_sel), .fast_en0(fast_en0), .fast_en1(fast_en1),
    .cmp_t1(cmp_t1), .cmp_t2(cmp_t2), .cmp_t4(cmp_t4), .cmp_teoc(cmp_teoc), .cmp_iordy_en(cmp_iordy_en),
    .f0_t1(f0_t1), .f0_t2(f0_t2), .f0_t4(f0_t4), .f0_teoc(f0_teoc), .f0_iordy_en(f0_iordy_en),
    .f1_t1(f1_t1), .f1_t2(f1_t2), .f1_t4(f1_t4), .f1_teoc(f1_teoc), .f1_iordy_en(f1_iordy_en),
    .iordy(iordy), .dd_in(dd_in), .dd_oe(dd_oe), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .rd_data(rd_data), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int m_first, m_last, m_scnt, m_oe_first, m_oe_after, m_done, m_dcnt, m_wrong, m_rdoe;
  int m_rdata;

  // rel: sample index from which iordy is high (0: always high); go_again: index of an extra go pulse
  task automatic run_access(input logic w, input logic [3:0] a, input logic d, input int rel,
                            input int go_again);
    int idx = 0;
    m_first = -1; m_last = -1; m_scnt = 0; m_oe_first = -1; m_oe_after = 0;
    m_done = -1; m_dcnt = 0; m_wrong = 0; m_rdoe = 0; m_rdata = -1;
    @(negedge clk);
    wr = w; addr = a; dev_sel = d; go = 1'b1;
    iordy = (rel == 0);
    dd_in = 16'hA000;
    while (idx < 700) begin
      logic st;
      @(negedge clk);
      idx++;
      st = w ? wr_strobe : rd_strobe;
      if (st) begin
        if (m_first < 0) m_first = idx;
        m_last = idx;
        m_scnt++;
      end
      if (w ? rd_strobe : wr_strobe) m_wrong++;
      if (dd_oe && m_oe_first < 0) m_oe_first = idx;
      if (dd_oe && !w) m_rdoe++;
      if (dd_oe && m_last > 0 && idx > m_last) m_oe_after++;
      if (done) begin
        m_dcnt++;
        if (m_done < 0) begin
          m_done = idx;
          m_rdata = int'(rd_data);
        end
      end
      go = (go_again > 0 && idx == go_again);
      dd_in = 16'hA000 + 16'(idx);
      iordy = (rel == 0) || (idx >= rel);
      if (m_done > 0 && idx >= m_done + 3) break;
    end
    go = 1'b0;
    iordy = 1'b1;
  endtask

  function automatic int imin(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  // Checks one access against the set (t1,t2,t4,te) and stall s
  task automatic verify(input logic w, input int t1, input int t2, input int t4, input int te,
                        input int s, input string ctx);
    check(m_first == t1 + 2, {"R1 strobe start ", ctx}, m_first, t1 + 2);
    check(m_scnt == t2 + 1 + s, {"R1/R6 strobe width ", ctx}, m_scnt, t2 + 1 + s);
    check(m_done == t1 + t2 + te + 4 + s, {"R1 done position ", ctx}, m_done, t1 + t2 + te + 4 + s);
    check(m_dcnt == 1, {"R2 done pulses ", ctx}, m_dcnt, 1);
    check(m_wrong == 0, {"R3/R4 opposite strobe ", ctx}, m_wrong, 0);
    if (w) begin
      check(m_oe_first == 1, {"R3 oe start ", ctx}, m_oe_first, 1);
      check(m_oe_after == imin(t4, te) + 1, {"R3 oe hold ", ctx}, m_oe_after, imin(t4, te) + 1);
    end else begin
      check(m_rdoe == 0, {"R4 oe on read ", ctx}, m_rdoe, 0);
      check(m_rdata == 32'hA000 + t1 + t2 + 2 + s, {"R4 read capture ", ctx}, m_rdata,
            32'hA000 + t1 + t2 + 2 + s);
    end
  endtask

  initial begin
    rst_n = 1'b0; sync_rst = 1'b0; go = 1'b0; wr = 1'b0; addr = 4'h1; dev_sel = 1'b0;
    fast_en0 = 1'b0; fast_en1 = 1'b0; iordy = 1'b1; dd_in = 16'h0;
    cmp_t1 = 8'd1; cmp_t2 = 8'd1; cmp_t4 = 8'd0; cmp_teoc = 8'd1; cmp_iordy_en = 1'b0;
    f0_t1 = 8'd3; f0_t2 = 8'd2; f0_t4 = 8'd1; f0_teoc = 8'd1; f0_iordy_en = 1'b1;
    f1_t1 = 8'd5; f1_t2 = 8'd4; f1_t4 = 8'd1; f1_teoc = 8'd2; f1_iordy_en = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!rd_strobe && !wr_strobe && !dd_oe && !done, "R8 reset outputs",
          {rd_strobe, wr_strobe, dd_oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: sweep of the compatible set on a command-port address
    for (int t1 = 0; t1 < 3; t1++)
      for (int t2 = 0; t2 < 3; t2++)
        for (int te = 0; te < 3; te++)
          for (int t4 = 0; t4 < 4; t4++)
            for (int w = 0; w < 2; w++) begin
              cmp_t1 = 8'(t1); cmp_t2 = 8'(t2); cmp_t4 = 8'(t4); cmp_teoc = 8'(te);
              run_access(w[0], 4'h1, 1'b0, 0, 0);
              verify(w[0], t1, t2, t4, te, 0, $sformatf("sweep t1=%0d t2=%0d t4=%0d te=%0d w=%0d", t1, t2, t4, te, w));
            end

    // R5 R6: set selection with iordy held low 3 extra cycles
    cmp_t1 = 8'd1; cmp_t2 = 8'd1; cmp_t4 = 8'd0; cmp_teoc = 8'd1; cmp_iordy_en = 1'b0;
    for (int ai = 0; ai < 4; ai++)
      for (int d = 0; d < 2; d++)
        for (int en = 0; en < 4; en++) begin
          logic [3:0] a;
          bit fast;
          int et1, et2, et4, ete, es;
          a = (ai == 0) ? 4'h0 : (ai == 1) ? 4'h1 : (ai == 2) ? 4'h6 : 4'h8;
          fast = (a == 4'h0) && en[d];
          if (!fast) begin et1 = 1; et2 = 1; et4 = 0; ete = 1; es = 0; end
          else if (d == 0) begin et1 = 3; et2 = 2; et4 = 1; ete = 1; es = 3; end
          else begin et1 = 5; et2 = 4; et4 = 1; ete = 2; es = 3; end
          fast_en0 = en[0]; fast_en1 = en[1];
          for (int w = 0; w < 2; w++) begin
            run_access(w[0], a, d[0], et1 + et2 + 2 + 3, 0);
            verify(w[0], et1, et2, et4, ete, es,
                   $sformatf("R5 select a=%0h dev=%0d en=%0d w=%0d", a, d, en, w));
          end
        end
    fast_en0 = 1'b0; fast_en1 = 1'b0;

    // R6: stretch lengths 1..6 on the compatible set with iordy enabled
    cmp_iordy_en = 1'b1; cmp_t1 = 8'd2; cmp_t2 = 8'd1; cmp_teoc = 8'd1; cmp_t4 = 8'd1;
    for (int s = 1; s < 7; s++) begin
      run_access(1'b0, 4'h2, 1'b0, 2 + 1 + 2 + s, 0);
      verify(1'b0, 2, 1, 1, 1, s, $sformatf("R6 stretch s=%0d", s));
    end
    cmp_iordy_en = 1'b0;

    // R7: extra go while busy, at several points of the access
    cmp_t1 = 8'd2; cmp_t2 = 8'd2; cmp_t4 = 8'd1; cmp_teoc = 8'd2;
    for (int gi = 1; gi < 9; gi++) begin
      int strobes;
      run_access(1'b1, 4'h3, 1'b0, 0, gi);
      verify(1'b1, 2, 2, 1, 2, 0, $sformatf("R7 busy go at %0d", gi));
      strobes = 0;
      repeat (20) begin
        @(negedge clk);
        if (rd_strobe || wr_strobe || dd_oe || done) strobes++;
      end
      check(strobes == 0, $sformatf("R7 quiet after busy go %0d", gi), strobes, 0);
    end

    // R8: synchronous and asynchronous abort during the strobe
    for (int k = 0; k < 2; k++) begin
      int seen;
      cmp_t1 = 8'd1; cmp_t2 = 8'd10; cmp_teoc = 8'd3;
      @(negedge clk);
      wr = 1'b1; addr = 4'h0; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      repeat (4) @(negedge clk);
      check(wr_strobe && dd_oe, "R8 access under way before abort", {wr_strobe, dd_oe}, 3);
      if (k == 0) sync_rst = 1'b1; else rst_n = 1'b0;
      @(negedge clk);
      check(!rd_strobe && !wr_strobe && !dd_oe && !done,
            k == 0 ? "R8 sync reset idle" : "R8 async reset idle",
            {rd_strobe, wr_strobe, dd_oe, done}, 0);
      sync_rst = 1'b0; rst_n = 1'b1;
      seen = 0;
      repeat (40) begin
        @(negedge clk);
        if (done || wr_strobe || dd_oe) seen++;
      end
      check(seen == 0, "R8 no done after abort", seen, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule